// File: doc/BRIEF.md
# Multiplexer Logic Cell with Master-Slave Storage Element

This block is a single programmable logic cell. A four-way multiplexer tree picks one of four data words, and that word feeds a storage element. Each of the tree's two select levels is formed from a pair of select pins. The upper select is the AND of its pair, and the lower select is the OR of its pair. So one cell can realise a wide family of small logic functions just by tying the data and select pins to signals or constants.

The storage element is a master latch followed by a slave latch. A small gating stage sits in front of it and derives the two latch enables and the internal clear from the clock, the clear pin and a mode input. In flip-flop mode the pair behaves as a rising-edge D flip-flop. In latch mode the master is held open, so the pair acts as one latch that is transparent while the clock is high. An active-high asynchronous clear forces the stored value to zero in both modes and overrides the clock.

Top module: `logic_cell_seq`

## Requirements
- R1: The upper select bit is 1 only when both `a1_i` and `b1_i` are 1.
- R2: The lower select bit is 1 when `a0_i` or `b0_i` (or both) is 1.
- R3: The tree outputs the data word indexed by {upper, lower} select: 00 gives `d00_i`, 01 gives `d01_i`, 10 gives `d10_i`, 11 gives `d11_i`.
- R4: With `mode_i` = 0 (flip-flop), `q_o` takes the tree output present at each rising edge of `clk_i`.
- R5: With `mode_i` = 0, `q_o` does not change between rising edges, across the falling edge and under any data or select change.
- R6: With `mode_i` = 1 (latch), `q_o` follows the tree output continuously while `clk_i` is high.
- R7: With `mode_i` = 1, `q_o` holds the tree output present at the falling edge for as long as `clk_i` is low.
- R8: While `clr_i` is 1, `q_o` is 0 in both modes, without waiting for a clock edge and whatever the clock, data and select pins do.
- R9: After `clr_i` falls, flip-flop mode keeps `q_o` at 0 until the next rising edge. Latch mode with the clock high passes the tree output at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d00_i | input | WIDTH | Data word chosen by select 00 |
| d01_i | input | WIDTH | Data word chosen by select 01 |
| d10_i | input | WIDTH | Data word chosen by select 10 |
| d11_i | input | WIDTH | Data word chosen by select 11 |
| a1_i | input | 1 | Upper select pin, ANDed with b1_i |
| b1_i | input | 1 | Upper select pin, ANDed with a1_i |
| a0_i | input | 1 | Lower select pin, ORed with b0_i |
| b0_i | input | 1 | Lower select pin, ORed with a0_i |
| clk_i | input | 1 | Storage clock |
| clr_i | input | 1 | Asynchronous clear, active high |
| mode_i | input | 1 | 0 selects flip-flop, 1 selects latch |
| q_o | output | WIDTH | Stored value |

## Verification
Assertions check the cycle-level storage behaviour on every clock edge:
- rising-edge capture, and holding through the falling edge, in flip-flop mode;
- transparency during the high phase, and holding during the low phase, in latch mode;
- a zero output whenever the clear is high at an edge.

Other behaviours can only be shown by the bench's scenarios:
- the select decoding over every pin combination;
- the clear acting mid-phase with no edge at all;
- the release of the clear into each mode.

The bench also shows data changes during the hold phases leaving the output untouched.

// File: rtl/logic_cell_pkg.sv
package logic_cell_pkg;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned N_DATA = 1 << SEL_W;

  typedef enum logic {
    MODE_FLOP  = 1'b0,
    MODE_LATCH = 1'b1
  } elem_mode_e;
endpackage

// File: rtl/cell_sel_gen.sv
module cell_sel_gen
  import logic_cell_pkg::*;
(
  input  logic             a1_i,
  input  logic             b1_i,
  input  logic             a0_i,
  input  logic             b0_i,
  output logic [SEL_W-1:0] sel_o
);
  assign sel_o[1] = a1_i & b1_i;
  assign sel_o[0] = a0_i | b0_i;
endmodule

// File: rtl/cell_mux_tree.sv
module cell_mux_tree
  import logic_cell_pkg::*;
#(
  parameter int unsigned WIDTH = 1
) (
  input  logic [N_DATA-1:0][WIDTH-1:0] d_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [WIDTH-1:0]             y_o
);
  localparam int unsigned N_PAIR = N_DATA / 2;

  logic [N_PAIR-1:0][WIDTH-1:0] lvl1;

  for (genvar p = 0; p < N_PAIR; p++) begin : g_lvl1
    assign lvl1[p] = sel_i[0] ? d_i[2*p+1] : d_i[2*p];
  end

  assign y_o = sel_i[1] ? lvl1[1] : lvl1[0];
endmodule

// File: rtl/cell_gate.sv
module cell_gate
  import logic_cell_pkg::*;
(
  input  logic       clk_i,
  input  logic       clr_i,
  input  elem_mode_e mode_i,
  output logic       mst_en_o,
  output logic       slv_en_o,
  output logic       clr_o
);
  // latch mode holds the master open so only the slave gates
  assign mst_en_o = ~clk_i | (mode_i == MODE_LATCH);
  assign slv_en_o = clk_i;
  assign clr_o    = clr_i;
endmodule

// File: rtl/cell_latch.sv
module cell_latch #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_latch begin
    if (clr_i)     q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/logic_cell_seq.sv
module logic_cell_seq
  import logic_cell_pkg::*;
#(
  parameter int unsigned WIDTH = 1
) (
  input  logic [WIDTH-1:0] d00_i,
  input  logic [WIDTH-1:0] d01_i,
  input  logic [WIDTH-1:0] d10_i,
  input  logic [WIDTH-1:0] d11_i,
  input  logic             a1_i,
  input  logic             b1_i,
  input  logic             a0_i,
  input  logic             b0_i,
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             mode_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned N_STAGE = 2;

  elem_mode_e                   mode;
  logic [SEL_W-1:0]             sel;
  logic [N_DATA-1:0][WIDTH-1:0] dvec;
  logic [WIDTH-1:0]             y;
  logic                         mst_en, slv_en, clr_int;
  logic [N_STAGE-1:0]           stg_en;
  logic [N_STAGE:0][WIDTH-1:0]  stg;

  assign mode = elem_mode_e'(mode_i);
  assign dvec = {d11_i, d10_i, d01_i, d00_i};

  cell_sel_gen u_sel (
    .a1_i (a1_i),
    .b1_i (b1_i),
    .a0_i (a0_i),
    .b0_i (b0_i),
    .sel_o(sel)
  );

  cell_mux_tree #(.WIDTH(WIDTH)) u_mux (
    .d_i  (dvec),
    .sel_i(sel),
    .y_o  (y)
  );

  cell_gate u_gate (
    .clk_i   (clk_i),
    .clr_i   (clr_i),
    .mode_i  (mode),
    .mst_en_o(mst_en),
    .slv_en_o(slv_en),
    .clr_o   (clr_int)
  );

  assign stg_en = {slv_en, mst_en};
  assign stg[0] = y;

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    cell_latch #(.WIDTH(WIDTH)) u_lat (
      .en_i (stg_en[s]),
      .clr_i(clr_int),
      .d_i  (stg[s]),
      .q_o  (stg[s+1])
    );
  end

  assign q_o = stg[N_STAGE];

  // checker state: values seen at the last rising and falling edges
  logic             cap_ok, fall_ok;
  elem_mode_e       cap_mode, fall_mode;
  logic [WIDTH-1:0] cap_y, fall_y;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      cap_ok   <= 1'b0;
      cap_mode <= MODE_FLOP;
      cap_y    <= '0;
    end else begin
      cap_ok   <= 1'b1;
      cap_mode <= mode;
      cap_y    <= y;
    end
  end

  always_ff @(negedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      fall_ok   <= 1'b0;
      fall_mode <= MODE_FLOP;
      fall_y    <= '0;
    end else begin
      fall_ok   <= 1'b1;
      fall_mode <= mode;
      fall_y    <= y;
    end
  end

  // R4
  ff_capture_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    (cap_ok && cap_mode == MODE_FLOP && mode == MODE_FLOP) |-> q_o == cap_y);

  // R5
  ff_hold_chk: assert property (@(negedge clk_i) disable iff (clr_i)
    (cap_ok && cap_mode == MODE_FLOP && mode == MODE_FLOP) |-> q_o == cap_y);

  // R6
  latch_follow_chk: assert property (@(negedge clk_i) disable iff (clr_i)
    (mode == MODE_LATCH) |-> q_o == y);

  // R7
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    (fall_ok && fall_mode == MODE_LATCH && mode == MODE_LATCH) |-> q_o == fall_y);

  // R8
  clear_zero_chk: assert property (@(posedge clk_i)
    clr_i |-> q_o == '0);
endmodule

// File: tb/logic_cell_seq_tb.sv
`timescale 1ns/1ps
module logic_cell_seq_tb;
  localparam int unsigned W = 1;
  localparam int unsigned WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         clr;
  logic         mode;
  logic [W-1:0] d00, d01, d10, d11;
  logic         a1, b1, a0, b0;
  logic [W-1:0] q;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  logic_cell_seq #(.WIDTH(W)) u_dut (
    .d00_i(d00), .d01_i(d01), .d10_i(d10), .d11_i(d11),
    .a1_i(a1), .b1_i(b1), .a0_i(a0), .b0_i(b0),
    .clk_i(clk), .clr_i(clr), .mode_i(mode), .q_o(q)
  );

  // pattern bits: 0..3 data d00,d01,d10,d11; 4 a0; 5 b0; 6 a1; 7 b1
  task automatic apply(input logic [7:0] v);
    {d11, d10, d01, d00} = v[3:0];
    a0 = v[4]; b0 = v[5]; a1 = v[6]; b1 = v[7];
  endtask

  function automatic logic [W-1:0] ref_y(input logic [7:0] v);
    int idx;
    idx = ((v[6] & v[7]) ? 2 : 0) + ((v[4] | v[5]) ? 1 : 0);
    return v[idx];
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic to_high();
    @(posedge clk); #0.5;
  endtask

  task automatic to_low();
    @(negedge clk); #0.5;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clr = 1'b1;
    mode = 1'b0;
    apply(8'h00);
    to_high(); to_high();
    chk("R8 reset", q, '0);

    // release clear in low phase, flop mode
    to_low();
    apply(8'h01);              // sel 00, d00=1
    clr = 1'b0;
    #0.5 chk("R9 flop stays 0 before edge", q, '0);
    to_high();
    chk("R9 flop captures after release", q, 1'b1);

    // exhaustive flop sweep
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] e;
      to_low();
      apply(v[7:0]);
      e = ref_y(v[7:0]);
      to_high();
      chk("R1/R2/R3/R4 capture", q, e);
      apply(~v[7:0]);
      #0.5 chk("R5 hold high phase", q, e);
      to_low();
      chk("R5 hold across fall", q, e);
    end

    // exhaustive latch sweep
    to_low();
    mode = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] v2;
      v2 = v[7:0] ^ 8'hA5;
      to_high();
      apply(v[7:0]);
      #0.5 chk("R6 transparent", q, ref_y(v[7:0]));
      apply(v2);
      #0.5 chk("R6 follows change", q, ref_y(v2));
      to_low();
      chk("R7 hold at fall", q, ref_y(v2));
      apply(~v2);
      #0.5 chk("R7 hold low phase", q, ref_y(v2));
    end

    // clear priority in flop mode
    to_low();
    mode = 1'b0;
    apply(8'h01);
    to_high();
    chk("R4 setup one", q, 1'b1);
    clr = 1'b1;
    #0.5 chk("R8 async clear mid high", q, '0);
    to_high();
    chk("R8 clear beats edge flop", q, '0);

    // clear priority in latch mode, release while high
    to_low();
    mode = 1'b1;
    to_high();
    chk("R8 clear beats latch", q, '0);
    clr = 1'b0;
    #0.5 chk("R9 latch passes on release", q, 1'b1);

    // short clear pulse in low phase, flop mode
    to_low();
    mode = 1'b0;
    to_high();
    chk("R4 recapture one", q, 1'b1);
    to_low();
    clr = 1'b1;
    #0.5 chk("R8 pulse clears in low phase", q, '0);
    clr = 1'b0;
    #0.5 chk("R9 stays 0 until edge", q, '0);
    to_high();
    chk("R9 capture after pulse", q, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule